// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This block produces a coarse estimate of 1/x for an IEEE single-precision operand. The estimate is bit-exact to a fixed integer recipe: the leading fraction bits of the normalised operand index a fixed-point divide, and the quotient is rounded and packed as the result fraction. It is a seed for a later refinement step, not a correctly rounded reciprocal. The divide runs serially, so one operation takes several cycles.

The caller pulses `start` with the operand and its controls: a rounding mode, flush-to-zero, default-NaN and an increased-precision select. The unit then returns the estimate and five exception flags together with a one-cycle `done` pulse. Special operands (NaN, infinity, zero, very small magnitudes, and the flush-to-zero underflow window) bypass the divider and finish one cycle after acceptance. A `start` is taken only while `busy` is low. A `start` presented in the same cycle as `done` is taken.

Top module: `recip_est_unit`

## Requirements
- R1: After reset `done`, `busy`, `result` and `flags` are all zero.
- R2: A zero operand returns infinity with the operand's sign and sets the divide-by-zero flag (flags bit 1).
- R3: An infinite operand returns zero with the operand's sign and sets no flag.
- R4: A NaN operand whose fraction bit 22 is clear (signalling) sets invalid (flags bit 0). Without default-NaN mode, a NaN is returned with fraction bit 22 forced to 1 and is otherwise unchanged. With default-NaN mode, every NaN returns 0x7FC00000, and a signalling one still sets invalid.
- R5: A nonzero operand with exponent field 0 and fraction bits 22:21 both zero sets overflow (bit 2) and inexact (bit 4). The result is signed infinity when the rounding mode is 0 (nearest), 1 (toward +inf) with a positive operand, or 2 (toward -inf) with a negative operand. For every other case it is the signed largest finite value 0x7F7FFFFF.
- R6: With flush-to-zero on, an operand whose biased exponent is 253 or more (and which is not infinite or NaN) returns a signed zero and sets underflow (bit 3).
- R7: With flush-to-zero on, a subnormal operand is treated as a zero of the same sign before any other rule is applied.
- R8: Normal estimate: s is 256 plus fraction bits 22:15. The unit computes q = floor(2^19/(2s+1)) and r = (q+1)>>1, which lies in 256..511. The result exponent is 253 minus the operand exponent. The result fraction is r[7:0] in bits 22:15 with zeros below. No flag is set.
- R9: With increased precision selected, s is 2048 plus fraction bits 22:12. The unit computes q = floor(2^26/(2s+1)) and r = (q+1)>>1, which lies in 4096..8191. The result fraction is r[11:0] in bits 22:11.
- R10: A subnormal operand without flush-to-zero is normalised first. If fraction bit 22 is clear, the working exponent is -1 and the fraction is shifted left by 2. Otherwise the working exponent is 0 and the fraction is shifted left by 1.
- R11: If the result exponent would be 0, the fraction is shifted right by 1 with a 1 in bit 22. If it would be -1, the fraction is shifted right by 2 with bits 22:21 = 01, and the exponent is 0.
- R12: Each accepted `start` gives exactly one `done` pulse, and results come back in acceptance order. A `start` while `busy` is high is ignored. A `start` in a `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken when busy is low) |
| operand | input | 32 | Single-precision operand |
| rmode | input | 2 | Rounding mode: 0 nearest, 1 toward +inf, 2 toward -inf, 3 toward zero |
| ftz | input | 1 | Flush-to-zero control |
| dnan | input | 1 | Default-NaN control |
| hiprec | input | 1 | Increased-precision select |
| busy | output | 1 | A divide is in flight |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 32 | Estimate (held until the next completion) |
| flags | output | 5 | Bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact |

## Verification
Two things can fall in the same cycle: the completion of one operation and the acceptance of the next. The bench raises `start` exactly in the `done` cycle. In one case the new operand is a special, so two completions arrive back to back. In another case a divider operation follows one that has just completed. The bench also drives `start` while `busy` is high and expects that request to leave no trace. The behavioural model queues one expected result per accepted start and pops one per `done`, so a lost, extra or reordered completion shows up as a mismatch or as an unexpected pulse.

// File: rtl/rcpe_pkg.sv
package rcpe_pkg;
    localparam int WORD_W     = 32;
    localparam int FRAC_W     = 23;
    localparam int WEXP_W     = 10;
    localparam int DIV_W      = 13;
    localparam int QUO_W      = 16;
    localparam int CNT_W      = 5;
    localparam int FLAG_W     = 5;
    localparam int NORM_ITERS = 20;
    localparam int HP_ITERS   = 27;
    localparam int EXP_ANCHOR = 253;

    localparam int FL_INV = 0;
    localparam int FL_DBZ = 1;
    localparam int FL_OVF = 2;
    localparam int FL_UNF = 3;
    localparam int FL_INX = 4;

    localparam logic [WORD_W-1:0] DEF_QNAN = 32'h7FC0_0000;
    localparam logic [WORD_W-2:0] INF_MAG  = 31'h7F80_0000;
    localparam logic [WORD_W-2:0] MAXN_MAG = 31'h7F7F_FFFF;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_POS     = 2'd1,
        RND_NEG     = 2'd2,
        RND_ZERO    = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/rcpe_classify.sv
module rcpe_classify
    import rcpe_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    input  logic [1:0]        rmode,
    input  logic              ftz,
    input  logic              dnan,
    input  logic              hiprec,
    output logic              special,
    output logic [WORD_W-1:0] spec_res,
    output logic [FLAG_W-1:0] spec_flags,
    output logic [WEXP_W-1:0] wexp,
    output logic [DIV_W-1:0]  divisor
);
    logic              sgn;
    logic [7:0]        ex;
    logic [FRAC_W-1:0] fr;
    logic [10:0]       top11;
    logic              to_inf;

    always_comb begin
        sgn = op[31];
        ex  = op[30:23];
        fr  = op[22:0];
        if (ftz && ex == 8'd0) begin
            fr = '0;
        end

        case (rnd_mode_e'(rmode))
            RND_NEAREST: to_inf = 1'b1;
            RND_POS:     to_inf = !sgn;
            RND_NEG:     to_inf = sgn;
            default:     to_inf = 1'b0;
        endcase

        special    = 1'b1;
        spec_res   = '0;
        spec_flags = '0;
        if (ex == 8'hFF && fr != '0) begin
            spec_flags[FL_INV] = !fr[22];
            spec_res = dnan ? DEF_QNAN : {op[31:23], 1'b1, fr[21:0]};
        end else if (ex == 8'hFF) begin
            spec_res = {sgn, 31'd0};
        end else if (ex == 8'd0 && fr == '0) begin
            spec_flags[FL_DBZ] = 1'b1;
            spec_res = {sgn, INF_MAG};
        end else if (ex == 8'd0 && fr[22:21] == 2'b00) begin
            spec_flags[FL_OVF] = 1'b1;
            spec_flags[FL_INX] = 1'b1;
            spec_res = {sgn, to_inf ? INF_MAG : MAXN_MAG};
        end else if (ftz && ex >= 8'(EXP_ANCHOR)) begin
            spec_flags[FL_UNF] = 1'b1;
            spec_res = {sgn, 31'd0};
        end else begin
            special = 1'b0;
        end

        // normalise: leading fraction bits after the subnormal shift
        if (ex == 8'd0) begin
            if (!fr[22]) begin
                wexp  = '1;
                top11 = fr[20:10];
            end else begin
                wexp  = '0;
                top11 = fr[21:11];
            end
        end else begin
            wexp  = {2'b00, ex};
            top11 = fr[22:12];
        end

        divisor = hiprec ? {1'b1, top11, 1'b1}
                         : {3'b000, 1'b1, top11[10:3], 1'b1};
    end
endmodule

// File: rtl/rcpe_divider.sv
module rcpe_divider #(
    parameter int DW = 13,
    parameter int QW = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] iters,
    input  logic [DW-1:0] divisor,
    output logic          valid,
    output logic [QW-1:0] quot
);
    localparam int TW = DW + 1;

    typedef struct packed {
        logic          run;
        logic          first;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dvs;
        logic [DW-1:0] rem;
        logic [QW-1:0] quo;
        logic          fin;
    } dv_t;

    dv_t         dv_q, dv_d;
    logic [TW-1:0] trial;

    always_comb begin
        dv_d     = dv_q;
        dv_d.fin = 1'b0;
        trial    = {dv_q.rem, dv_q.first};
        if (load) begin
            dv_d.run   = 1'b1;
            dv_d.first = 1'b1;
            dv_d.cnt   = iters;
            dv_d.dvs   = divisor;
            dv_d.rem   = '0;
            dv_d.quo   = '0;
        end else if (dv_q.run) begin
            if (trial >= {1'b0, dv_q.dvs}) begin
                dv_d.rem = DW'(trial - {1'b0, dv_q.dvs});
                dv_d.quo = {dv_q.quo[QW-2:0], 1'b1};
            end else begin
                dv_d.rem = trial[DW-1:0];
                dv_d.quo = {dv_q.quo[QW-2:0], 1'b0};
            end
            dv_d.first = 1'b0;
            dv_d.cnt   = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.run = 1'b0;
                dv_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign valid = dv_q.fin;
    assign quot  = dv_q.quo;

    // R12: a new divide is never loaded over one in flight
    a_r12_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !dv_q.run);
    // R12: completion of the divide is a single-cycle event
    a_r12_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/rcpe_pack.sv
module rcpe_pack
    import rcpe_pkg::*;
(
    input  logic [QUO_W-1:0]  quot,
    input  logic              hp,
    input  logic              sgn,
    input  logic [WEXP_W-1:0] wexp,
    output logic [QUO_W-1:0]  est,
    output logic [WORD_W-1:0] res
);
    logic [WEXP_W-1:0] rexp;
    logic [FRAC_W-1:0] frac;
    logic [7:0]        eo;

    always_comb begin
        est  = QUO_W'(({1'b0, quot} + 1'b1) >> 1);
        frac = hp ? {est[11:0], 11'd0} : {est[7:0], 15'd0};
        rexp = WEXP_W'(EXP_ANCHOR) - wexp;
        if (rexp == '0) begin
            frac = {1'b1, frac[22:1]};
            eo   = 8'd0;
        end else if (rexp == '1) begin
            frac = {2'b01, frac[22:2]};
            eo   = 8'd0;
        end else begin
            eo   = rexp[7:0];
        end
        res = {sgn, eo, frac};
    end
endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit
    import rcpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] operand,
    input  logic [1:0]        rmode,
    input  logic              ftz,
    input  logic              dnan,
    input  logic              hiprec,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    typedef struct packed {
        logic              run;
        logic              sgn;
        logic [WEXP_W-1:0] wexp;
        logic              hp;
        logic [WORD_W-1:0] res;
        logic [FLAG_W-1:0] flg;
        logic              done;
    } st_t;

    st_t st_q, st_d;

    logic              c_special;
    logic [WORD_W-1:0] c_res;
    logic [FLAG_W-1:0] c_flags;
    logic [WEXP_W-1:0] c_wexp;
    logic [DIV_W-1:0]  c_divisor;
    logic              div_load;
    logic              div_valid;
    logic [QUO_W-1:0]  div_quot;
    logic [CNT_W-1:0]  div_iters;
    logic [QUO_W-1:0]  p_est;
    logic [WORD_W-1:0] p_res;

    rcpe_classify u_classify (
        .op(operand), .rmode(rmode), .ftz(ftz), .dnan(dnan), .hiprec(hiprec),
        .special(c_special), .spec_res(c_res), .spec_flags(c_flags),
        .wexp(c_wexp), .divisor(c_divisor)
    );

    assign div_iters = hiprec ? CNT_W'(HP_ITERS) : CNT_W'(NORM_ITERS);

    rcpe_divider #(.DW(DIV_W), .QW(QUO_W), .CW(CNT_W)) u_divider (
        .clk(clk), .rst_n(rst_n), .load(div_load), .iters(div_iters),
        .divisor(c_divisor), .valid(div_valid), .quot(div_quot)
    );

    rcpe_pack u_pack (
        .quot(div_quot), .hp(st_q.hp), .sgn(st_q.sgn), .wexp(st_q.wexp),
        .est(p_est), .res(p_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        div_load  = 1'b0;
        if (!st_q.run && start) begin
            if (c_special) begin
                st_d.res  = c_res;
                st_d.flg  = c_flags;
                st_d.done = 1'b1;
            end else begin
                st_d.run  = 1'b1;
                st_d.sgn  = operand[31];
                st_d.wexp = c_wexp;
                st_d.hp   = hiprec;
                div_load  = 1'b1;
            end
        end
        if (st_q.run && div_valid) begin
            st_d.res  = p_res;
            st_d.flg  = '0;
            st_d.done = 1'b1;
            st_d.run  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.run;
    assign done   = st_q.done;
    assign result = st_q.res;
    assign flags  = st_q.flg;

    // R2: divide-by-zero always comes with an infinite magnitude
    a_r2_dbz_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FL_DBZ]) |-> (result[30:0] == INF_MAG));
    // R5: overflow and inexact are raised together
    a_r5_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[FL_OVF] == flags[FL_INX]));
    // R6: underflow always returns a zero magnitude
    a_r6_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FL_UNF]) |-> (result[30:0] == 31'd0));
    // R8: the rounded quotient of the normal core stays in 256..511
    a_r8_est_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && div_valid && !st_q.hp) |-> (p_est >= 16'd256 && p_est <= 16'd511));
    // R9: the rounded quotient of the wide core stays in 4096..8191
    a_r9_est_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && div_valid && st_q.hp) |-> (p_est >= 16'd4096 && p_est <= 16'd8191));
    // R12: every done follows an accepted start or a finished divide
    a_r12_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start && !busy) || $past(div_valid)));
endmodule

// File: tb/recip_est_unit_bench.sv
module recip_est_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  rmode = '0;
    logic        ftz = 1'b0, dnan = 1'b0, hiprec = 1'b0;
    logic        busy, done;
    logic [31:0] result;
    logic [4:0]  flags;

    always #5 clk = ~clk;

    recip_est_unit u_recip_est_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .rmode(rmode),
        .ftz(ftz), .dnan(dnan), .hiprec(hiprec), .busy(busy), .done(done),
        .result(result), .flags(flags)
    );

    int checks = 0, errors = 0, dones = 0, pushes = 0;
    logic [36:0] expq[$];
    string       tagq[$];

    function automatic logic [36:0] ref_model(input logic [31:0] x, input logic [1:0] rm,
                                              input logic fz, input logic dn, input logic hp);
        longint e, f, s, a, b, r, fr, re;
        logic sg;
        logic [4:0] fl;
        logic [31:0] res;
        sg = x[31]; e = longint'(x[30:23]); f = longint'(x[22:0]); fl = '0;
        if (fz && e == 0) f = 0;
        if (e == 255 && f != 0) begin
            if (f < 4194304) fl[0] = 1'b1;
            res = dn ? 32'h7FC00000 : (x | 32'h00400000);
        end else if (e == 255) begin
            res = {sg, 31'd0};
        end else if (e == 0 && f == 0) begin
            fl[1] = 1'b1; res = {sg, 31'h7F800000};
        end else if (e == 0 && f < 2097152) begin
            fl[2] = 1'b1; fl[4] = 1'b1;
            if (rm == 2'd0 || (rm == 2'd1 && !sg) || (rm == 2'd2 && sg)) res = {sg, 31'h7F800000};
            else res = {sg, 31'h7F7FFFFF};
        end else if (fz && e >= 253) begin
            fl[3] = 1'b1; res = {sg, 31'd0};
        end else begin
            if (e == 0) begin
                if (f < 4194304) begin e = -1; f = (f * 4) % 8388608; end
                else f = (f * 2) % 8388608;
            end
            if (hp) begin
                s = 2048 + f / 4096; a = 2 * s + 1; b = 67108864 / a;
                r = (b + 1) / 2; fr = (r % 4096) * 2048;
            end else begin
                s = 256 + f / 32768; a = 2 * s + 1; b = 524288 / a;
                r = (b + 1) / 2; fr = (r % 256) * 32768;
            end
            re = 253 - e;
            if (re == 0) fr = fr / 2 + 4194304;
            else if (re == -1) begin fr = fr / 4 + 2097152; re = 0; end
            res = {sg, re[7:0], fr[22:0]};
        end
        return {fl, res};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the queued model results
    always @(negedge clk) begin : monitor
        logic [36:0] ev;
        string tv;
        if (rst_n && done) begin
            dones++;
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected done actual=%h expected=none", {flags, result});
            end else begin
                ev = expq.pop_front();
                tv = tagq.pop_front();
                check(tv, 64'({flags, result}), 64'(ev));
            end
        end
    end

    task automatic drive(input logic [31:0] x, input logic [1:0] rm, input logic fz,
                         input logic dn, input logic hp, input string tag);
        operand = x; rmode = rm; ftz = fz; dnan = dn; hiprec = hp; start = 1'b1;
        if (!busy) begin
            expq.push_back(ref_model(x, rm, fz, dn, hp));
            tagq.push_back(tag);
            pushes++;
        end
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((expq.size() != 0 || busy) && n < 200) begin
            @(negedge clk); #1;
            n++;
        end
        if (n >= 200) begin
            checks++; errors++;
            $display("FAIL R12 drain timeout actual=pending expected=idle");
        end
    endtask

    task automatic one(input logic [31:0] x, input logic [1:0] rm, input logic fz,
                       input logic dn, input logic hp, input string tag);
        drive(x, rm, fz, dn, hp, tag);
        drain();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 reset state", 64'({busy, done, flags, result}), 64'd0);

        one(32'h00000000, 2'd0, 0, 0, 0, "R2 +zero");
        one(32'h80000000, 2'd0, 0, 0, 0, "R2 -zero");
        one(32'h7F800000, 2'd0, 0, 0, 0, "R3 +inf");
        one(32'hFF800000, 2'd3, 0, 0, 0, "R3 -inf");
        one(32'h7F800001, 2'd0, 0, 0, 0, "R4 snan quieted");
        one(32'hFFC12345, 2'd0, 0, 0, 0, "R4 qnan passthrough");
        one(32'h7FA00000, 2'd0, 0, 1, 0, "R4 snan default");
        one(32'hFFC00001, 2'd0, 0, 1, 0, "R4 qnan default");
        one(32'h00100000, 2'd0, 0, 0, 0, "R5 tiny nearest");
        one(32'h80000001, 2'd1, 0, 0, 0, "R5 tiny neg up");
        one(32'h80000001, 2'd2, 0, 0, 0, "R5 tiny neg down");
        one(32'h00000001, 2'd3, 0, 0, 0, "R5 tiny zero mode");
        one(32'h00000001, 2'd2, 0, 0, 0, "R5 tiny pos down");
        one(32'h7E800000, 2'd0, 1, 0, 0, "R6 exp253 ftz");
        one(32'hFF000000, 2'd0, 1, 0, 0, "R6 exp254 ftz");
        one(32'h00400000, 2'd0, 1, 0, 0, "R7 subnormal flushed");
        one(32'h80300000, 2'd0, 1, 0, 0, "R7 neg subnormal flushed");
        one(32'h3F800000, 2'd0, 0, 0, 0, "R8 one");
        one(32'h40490FDB, 2'd1, 0, 0, 0, "R8 pi");
        one(32'hC1200000, 2'd0, 0, 0, 0, "R8 -ten");
        one(32'h3F800000, 2'd0, 0, 0, 1, "R9 one wide");
        one(32'h3FC00000, 2'd0, 0, 0, 1, "R9 1.5 wide");
        one(32'hC2F6E979, 2'd0, 0, 0, 1, "R9 neg wide");
        one(32'h00400000, 2'd0, 0, 0, 0, "R10 subnormal top bit");
        one(32'h00200000, 2'd0, 0, 0, 0, "R10 subnormal second bit");
        one(32'h80712345, 2'd0, 0, 0, 1, "R10 subnormal wide");
        one(32'h7E800000, 2'd0, 0, 0, 0, "R11 exp253 denorm out");
        one(32'hFF000000, 2'd0, 0, 0, 0, "R11 exp254 denorm out");
        one(32'h7F2AAAAA, 2'd0, 0, 0, 1, "R11 wide denorm out");

        // R12: start while busy is ignored, start in the done cycle is taken
        drive(32'h40000000, 2'd0, 0, 0, 0, "R12 first op");
        for (int i = 0; i < 5; i++) begin
            operand = 32'h3F800000; start = 1'b1;
            @(negedge clk); #1;
        end
        start = 1'b0;
        begin
            int n = 0;
            while (!done && n < 100) begin @(negedge clk); #1; n++; end
        end
        drive(32'h80000000, 2'd0, 0, 0, 0, "R12 special in done cycle");
        drive(32'h41000000, 2'd0, 0, 0, 1, "R12 divide in done cycle");
        drain();
        check("R12 done count", 64'(dones), 64'(pushes));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule